// File: doc/BRIEF.md
# Phased Parallel I/O Port

This block is a byte-wide parallel port for a small processor whose bus machine cycles are divided into four successive states. A 2-bit state code tells the port where the current cycle stands. Separate read-cycle and write-cycle strobes, together with a port-select hit, mark the cycles that address the port. An output latch drives the pins continuously and is loaded only at one fixed state of a selected write cycle. Input pins have no latch of their own. They pass through a short synchronizer and are captured into the read-data register at one fixed state of a selected read cycle.

A per-access source flag, supplied by the instruction decoder, decides what a read returns. Read-modify-write accesses (single-bit set, clear or complement, exchange, or the destination operand of an arithmetic or logic operation) see the output latch. Every other read, including the memory-operand side of a two-operand operation, sees the synchronized pin level. Because the pins are looked at only at one instant, glitches and chatter outside that instant never reach the bus. Any filtering is left to software.

Top module: `ppio_port`

## Requirements
- R1: While reset is high at a clock edge, the output latch (and so `pin_o`) is loaded with all ones and `rdata_o` is cleared to zero; both are visible from the following cycle.
- R2: The state input encodes S0=00, S1=01, S2=10, S3=11, one state per clock. A write is taken when `wr_cyc_i` and `sel_i` are high in state S2. The latch takes `wdata_i` at the edge that closes S2. `pin_o` keeps the old value through S2 and shows the new one from S3 on.
- R3: A write strobe with `sel_i` low, or one present only in S0, S1 or S3, leaves `pin_o` unchanged.
- R4: Between accepted writes the latch keeps its value, and `pin_o` always equals the latch.
- R5: When `rd_cyc_i` and `sel_i` are high in S1 and `rmw_src_i` is 0, `rdata_o` takes the pin level as synchronized by `SYNC_STAGES` (default 2) flops at the edge that closes S1. That is the level `pin_i` held at the edge two clocks before, which is the edge closing S3 of the previous cycle.
- R6: When `rd_cyc_i` and `sel_i` are high in S1 and `rmw_src_i` is 1, `rdata_o` takes the latch contents as they stand during S1. In a cycle that both reads and writes, this is the value from before the write.
- R7: `rdata_o` changes only at the edge that closes S1 of a selected read. A read strobe without `sel_i`, or one present only outside S1, leaves it unchanged, and a captured value stays put through S2 and S3.
- R8: A pin change that arrives after the edge closing S3 of the previous cycle is not seen by the read. This covers a change during S0 of the read cycle and a change after the sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bus state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 2 | Current bus state S0..S3 |
| rd_cyc_i | input | 1 | Read cycle strobe |
| wr_cyc_i | input | 1 | Write cycle strobe |
| sel_i | input | 1 | Address decode hit for this port |
| rmw_src_i | input | 1 | 1: read returns latch, 0: read returns pins |
| wdata_i | input | WIDTH | Write data bus |
| pin_i | input | WIDTH | Pin input levels |
| pin_o | output | WIDTH | Pin output levels from the latch |
| rdata_o | output | WIDTH | Registered read data |

## Verification
Several properties are checked on every cycle: loading of the latch at the S2 edge, the latch holding whenever no selected S2 write is present, the read register holding outside a selected S1 read, a latch-sourced read returning the latch value, and the reset values. The pin-sourced path depends on the synchronizer's depth and on exactly when a pin changes relative to the sample edge. Only the bench scenarios can show that path: pin changes in S0 and after the sample, and reads and writes landing in the same cycle.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
   typedef enum logic [1:0] {
      ST_S0 = 2'b00,
      ST_S1 = 2'b01,
      ST_S2 = 2'b10,
      ST_S3 = 2'b11
   } bus_state_e;

   localparam bus_state_e SAMPLE_STATE = ST_S1;
   localparam bus_state_e UPDATE_STATE = ST_S2;
   localparam int         MAX_SYNC     = 4;
endpackage

// File: rtl/ppio_sync.sv
module ppio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ppio_phase_dec.sv
module ppio_phase_dec
   import ppio_pkg::*;
(
   input  logic [1:0] phase_i,
   input  logic       rd_cyc_i,
   input  logic       wr_cyc_i,
   input  logic       sel_i,
   output logic       rd_hit_o,
   output logic       wr_hit_o
);
   bus_state_e state;

   always_comb begin
      state    = bus_state_e'(phase_i);
      rd_hit_o = rd_cyc_i && sel_i && (state == SAMPLE_STATE);
      wr_hit_o = wr_cyc_i && sel_i && (state == UPDATE_STATE);
   end
endmodule

// File: rtl/ppio_out_latch.sv
module ppio_out_latch #(
   parameter int               WIDTH    = 8,
   parameter logic [WIDTH-1:0] INIT_VAL = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (rst)         bit_q <= INIT_VAL[b];
            else if (load_i) bit_q <= d_i[b];
         end
         assign q_o[b] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/ppio_read_sel.sv
module ppio_read_sel #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture_i,
   input  logic             use_latch_i,
   input  logic [WIDTH-1:0] latch_i,
   input  logic [WIDTH-1:0] pins_i,
   output logic [WIDTH-1:0] rdata_o
);
   logic [WIDTH-1:0] src_d;

   always_comb src_d = use_latch_i ? latch_i : pins_i;

   always_ff @(posedge clk) begin
      if (rst)            rdata_o <= '0;
      else if (capture_i) rdata_o <= src_d;
   end
endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] LATCH_INIT  = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       phase_i,
   input  logic             rd_cyc_i,
   input  logic             wr_cyc_i,
   input  logic             sel_i,
   input  logic             rmw_src_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] pin_o,
   output logic [WIDTH-1:0] rdata_o
);
   localparam int SYNC_LIMIT = ppio_pkg::MAX_SYNC;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ppio_port: WIDTH must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > SYNC_LIMIT) begin : g_bad_sync
         $error("ppio_port: SYNC_STAGES out of range");
      end
   endgenerate

   logic             rd_hit;
   logic             wr_hit;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pins_sync;

   ppio_phase_dec u_dec (
      .phase_i  (phase_i),
      .rd_cyc_i (rd_cyc_i),
      .wr_cyc_i (wr_cyc_i),
      .sel_i    (sel_i),
      .rd_hit_o (rd_hit),
      .wr_hit_o (wr_hit)
   );

   ppio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pin_i),
      .q_o (pins_sync)
   );

   ppio_out_latch #(.WIDTH(WIDTH), .INIT_VAL(LATCH_INIT)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .load_i (wr_hit),
      .d_i    (wdata_i),
      .q_o    (latch_q)
   );

   ppio_read_sel #(.WIDTH(WIDTH)) u_rsel (
      .clk         (clk),
      .rst         (rst),
      .capture_i   (rd_hit),
      .use_latch_i (rmw_src_i),
      .latch_i     (latch_q),
      .pins_i      (pins_sync),
      .rdata_o     (rdata_o)
   );

   assign pin_o = latch_q;
endmodule

// File: rtl/ppio_port_chk.sv
module ppio_port_chk
   import ppio_pkg::*;
#(
   parameter int               WIDTH      = 8,
   parameter logic [WIDTH-1:0] LATCH_INIT = '1
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       phase_i,
   input logic             rd_cyc_i,
   input logic             wr_cyc_i,
   input logic             sel_i,
   input logic             rmw_src_i,
   input logic [WIDTH-1:0] wdata_i,
   input logic [WIDTH-1:0] pin_o,
   input logic [WIDTH-1:0] rdata_o
);
   // R1: reset values
   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (pin_o == LATCH_INIT && rdata_o == '0));

   // R2: selected write in S2 loads the bus value
   p_latch_load_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_cyc_i && sel_i && phase_i == ST_S2) |=> (pin_o == $past(wdata_i)));

   // R3 / R4: no accepted write, no latch change
   p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !(wr_cyc_i && sel_i && phase_i == ST_S2) |=> $stable(pin_o));

   // R6: latch-sourced read returns the latch seen during S1
   p_rmw_src_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_cyc_i && sel_i && phase_i == ST_S1 && rmw_src_i) |=> (rdata_o == $past(pin_o)));

   // R7: read data moves only on a selected S1 read
   p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(rd_cyc_i && sel_i && phase_i == ST_S1) |=> $stable(rdata_o));
endmodule

bind ppio_port ppio_port_chk #(.WIDTH(WIDTH), .LATCH_INIT(LATCH_INIT)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .phase_i   (phase_i),
   .rd_cyc_i  (rd_cyc_i),
   .wr_cyc_i  (wr_cyc_i),
   .sel_i     (sel_i),
   .rmw_src_i (rmw_src_i),
   .wdata_i   (wdata_i),
   .pin_o     (pin_o),
   .rdata_o   (rdata_o)
);

// File: tb/ppio_port_bench.sv
module ppio_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   phase = 2'd0;
   logic         rd_cyc = 1'b0, wr_cyc = 1'b0, sel = 1'b0, rmw = 1'b0;
   logic [W-1:0] wdata = '0, pins = '0;
   logic [W-1:0] pin_o, rdata;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_latch = '1;
   logic [W-1:0] m_rd    = '0;
   logic [2*W-1:0] exp_q [$];
   string          tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ppio_port #(.WIDTH(W)) u_ppio_port (
      .clk       (clk),
      .rst       (rst),
      .phase_i   (phase),
      .rd_cyc_i  (rd_cyc),
      .wr_cyc_i  (wr_cyc),
      .sel_i     (sel),
      .rmw_src_i (rmw),
      .wdata_i   (wdata),
      .pin_i     (pins),
      .pin_o     (pin_o),
      .rdata_o   (rdata)
   );

   task automatic check(input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per bus cycle, compares in S3
   initial begin
      logic [2*W-1:0] e;
      string          t;
      forever begin
         @(negedge clk);
         #1;
         if (phase == 2'd3 && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "rdata in S3", rdata, e[W-1:0]);
            check(t, "pin_o in S3", pin_o, e[2*W-1:W]);
         end
      end
   end

   // driver: one four-state bus cycle; pushes the expected result
   task automatic bus_cycle(input logic [3:0] rdm, input logic [3:0] wrm,
                            input logic s, input logic r, input logic [W-1:0] wd,
                            input int chg_ph, input logic [W-1:0] chg_val,
                            input string tag);
      logic [W-1:0] pre_pins;
      logic [W-1:0] old_latch;
      pre_pins  = pins;
      old_latch = m_latch;
      if (wrm[2] && s) m_latch = wd;
      if (rdm[1] && s) m_rd = r ? old_latch : pre_pins;
      for (int p = 0; p < 4; p++) begin
         @(negedge clk);
         if (p == 2) begin
            check(tag, "pin_o during S2", pin_o, old_latch);
            check(tag, "rdata during S2", rdata, m_rd);
            exp_q.push_back({m_latch, m_rd});
            tag_q.push_back(tag);
         end
         phase  = p[1:0];
         rd_cyc = rdm[p];
         wr_cyc = wrm[p];
         sel    = s;
         rmw    = r;
         wdata  = wd;
         if (p == chg_ph) pins = chg_val;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "pin_o after reset", pin_o, 8'hFF);
      check("R1", "rdata after reset", rdata, 8'h00);

      bus_cycle(4'b0000, 4'b0100, 1'b1, 1'b0, 8'h5A, -1, '0, "R2 write in S2");
      bus_cycle(4'b0000, 4'b0100, 1'b0, 1'b0, 8'h33, -1, '0, "R3 write without select");
      bus_cycle(4'b0000, 4'b1011, 1'b1, 1'b0, 8'hC6, -1, '0, "R3 write strobe outside S2");
      bus_cycle(4'b0000, 4'b0000, 1'b1, 1'b0, 8'h11, -1, '0, "R4 latch holds idle");
      bus_cycle(4'b0000, 4'b0000, 1'b0, 1'b1, 8'h22, -1, '0, "R4 latch holds idle");

      pins = 8'hC3;
      bus_cycle(4'b0010, 4'b0000, 1'b1, 1'b0, 8'h00, -1, '0, "R5 pin read");
      bus_cycle(4'b0010, 4'b0000, 1'b1, 1'b1, 8'h00, -1, '0, "R6 latch read");

      pins = 8'h81;
      bus_cycle(4'b0010, 4'b0000, 1'b1, 1'b0, 8'h00, 0, 8'h0F, "R8 pin change in S0");
      bus_cycle(4'b0010, 4'b0000, 1'b0, 1'b0, 8'h00, 1, 8'h77, "R7 read without select");
      bus_cycle(4'b1101, 4'b0000, 1'b1, 1'b0, 8'h00, -1, '0, "R7 read strobe outside S1");
      bus_cycle(4'b0010, 4'b0000, 1'b1, 1'b0, 8'h00, 2, 8'h00, "R8 pin change after sample");
      bus_cycle(4'b0010, 4'b0000, 1'b1, 1'b0, 8'h00, -1, '0, "R5 pin read zero");

      bus_cycle(4'b0000, 4'b0100, 1'b1, 1'b0, 8'hA5, -1, '0, "R2 write second value");
      bus_cycle(4'b0010, 4'b0100, 1'b1, 1'b1, 8'h3C, -1, '0, "R6 read-modify-write cycle");
      bus_cycle(4'b0010, 4'b0000, 1'b1, 1'b1, 8'h00, -1, '0, "R6 latch read after write");
      pins = 8'hE7;
      bus_cycle(4'b0010, 4'b0000, 1'b1, 1'b0, 8'h00, -1, '0, "R5 pins differ from latch");

      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      m_latch = '1;
      m_rd    = '0;
      check("R1", "pin_o after second reset", pin_o, 8'hFF);
      check("R1", "rdata after second reset", rdata, 8'h00);
      bus_cycle(4'b0000, 4'b0000, 1'b1, 1'b0, 8'h00, -1, '0, "R1 reset state kept");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard R7 actual=%0d expected=0 items left", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule